// File: doc/BRIEF.md
# Checkerboard Lattice Gibbs Sampler

The block holds an N-by-N square lattice of binary variables and runs Gibbs sampling over it. The lattice is split into two colours by the parity of row plus column, so no two adjacent sites share a colour. Sites of one colour are conditionally independent given the other colour, so every site of a colour draws its new value in the same phase. A sweep is two back-to-back phases, even colour first, and its length does not depend on the lattice size. The logic grows with the number of sites.

Each site unit counts how many of its four neighbours are 1, looks that count up in a shared five-entry table of probabilities, and compares the entry with a fresh draw from its own pseudo-random generator. This takes three cycles. A controller starts on a pulse, runs a programmed number of sweeps, and then pulses a done flag. The whole lattice can be seeded while idle. An optional fault mode flips stored site values at random so the sampler's tolerance to upsets can be studied.

The pins are plain control and status signals; no interface here carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `lattice_gibbs_top`

## Requirements
- R1: After reset the lattice state is all zeros and both `busy` and `sweep_done` are low.
- R2: While idle, a cycle with `init_load` high copies `init_state` into the lattice, visible after that clock edge. Site (r,c) is bit r*N+c.
- R3: An updating site with k neighbours equal to 1 becomes 1 with probability T[k]/2^PW. T[k] is the field `cpt_thr[k*(PW+1) +: PW+1]`. An entry of 0 always gives 0 and an entry of 2^PW always gives 1.
- R4: In a sweep, the sites with even r+c update first from the current odd values. The odd sites then update from the new even values.
- R5: A neighbour position that lies outside the lattice reads as 0.
- R6: Each phase takes 3 cycles and there is no gap between phases or between sweeps. With S sweeps, `sweep_done` is high exactly 6*S cycles after the edge that samples `start`, and each colour's new values appear at the end of its phase.
- R7: Inside a run, the sites of the colour that is not updating hold their values. No site changes except at the last edge of a phase.
- R8: `sweep_done` is a one-cycle pulse and `busy` falls in the same cycle. A target of S >= 1 runs S sweeps; a target of 0 runs one sweep.
- R9: While busy, `start`, `sweep_target` and `init_load` are ignored.
- R10: With `fault_en` high, a site that is not writing a sample in a cycle flips with probability `fault_thr`/2^PW. A `fault_thr` of 0 never flips and 2^PW flips every cycle. With `fault_en` low, no fault flips occur.
- R11: Each site draws from its own generator, so a table of all half-probability entries leaves a lattice with a mix of ones and zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run while idle |
| sweep_target | input | CW | Number of sweeps to run, latched at start |
| cpt_thr | input | 5*(PW+1) | Probability table indexed by neighbour count |
| init_load | input | 1 | Seed the lattice while idle |
| init_state | input | N*N | Seed values, bit r*N+c |
| fault_en | input | 1 | Enable random state flips |
| fault_thr | input | PW+1 | Flip probability in units of 2^-PW |
| lattice_state | output | N*N | Current site values, bit r*N+c |
| busy | output | 1 | A run is in progress |
| sweep_done | output | 1 | One-cycle pulse when the run ends |

## Verification
The bench uses tables whose entries are all either certain 0 or certain 1, which makes the sampler deterministic. It then predicts every intermediate lattice cycle by cycle. A design that updated both colours together, or read old even values in the odd phase, would diverge right after the first phase. Seeding all ones with only count 4 certain shows whether border neighbours read as 1, which would leave the edge rows set. A second `start` and a load issued mid-run must leave the trajectory and the end time unchanged. A target of zero must still give a single six-cycle sweep. Full-rate faults while idle must invert the whole lattice on each cycle, and a zero rate must change nothing.

// File: rtl/gibbs_pkg.sv
package gibbs_pkg;

  typedef enum logic {CTL_IDLE, CTL_RUN} ctl_mode_e;

  // Distinct non-zero generator seed for each site
  function automatic logic [31:0] site_seed(input logic [31:0] base, input int idx);
    logic [31:0] s;
    s = base ^ (32'(idx + 1) * 32'h9E37_79B9);
    s = s ^ (s >> 16) ^ (s << 7);
    if (s == 32'h0) s = 32'h1;
    return s;
  endfunction

  function automatic logic [2:0] ones4(input logic [3:0] v);
    return {2'b0, v[0]} + {2'b0, v[1]} + {2'b0, v[2]} + {2'b0, v[3]};
  endfunction

endpackage

// File: rtl/gibbs_prng.sv
module gibbs_prng #(
  parameter logic [31:0] SEED = 32'h1,
  parameter int          OW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [OW-1:0] rnd
);
  logic [31:0] s_q, t1, t2, t3;

  always_comb begin
    t1 = s_q ^ (s_q << 13);
    t2 = t1 ^ (t1 >> 17);
    t3 = t2 ^ (t2 << 5);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) s_q <= SEED;
    else        s_q <= t3;
  end

  assign rnd = s_q[OW-1:0];
endmodule

// File: rtl/gibbs_site.sv
module gibbs_site
  import gibbs_pkg::*;
#(
  parameter int          PW     = 8,
  parameter logic [31:0] SEED   = 32'h1,
  parameter int          COLOUR = 0,
  localparam int         TW     = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          phase,
  input  logic [1:0]    stage,
  input  logic [3:0]    nbr,
  input  logic [5*TW-1:0] cpt_thr,
  input  logic          fault_en,
  input  logic [TW-1:0] fault_thr,
  input  logic          load,
  input  logic          load_val,
  output logic          state
);
  localparam logic MY_COL = (COLOUR % 2) == 1;

  logic [2*PW-1:0] rnd;
  logic [2:0]      cnt_q;
  logic [TW-1:0]   thr_q, sel;
  logic            active, fault_hit, st_q;

  gibbs_prng #(.SEED(SEED), .OW(2*PW)) u_prng (
    .clk(clk), .rst_n(rst_n), .rnd(rnd)
  );

  assign active    = run && (phase == MY_COL);
  assign fault_hit = fault_en && ({1'b0, rnd[2*PW-1:PW]} < fault_thr);

  always_comb begin
    case (cnt_q)
      3'd0:    sel = cpt_thr[0*TW +: TW];
      3'd1:    sel = cpt_thr[1*TW +: TW];
      3'd2:    sel = cpt_thr[2*TW +: TW];
      3'd3:    sel = cpt_thr[3*TW +: TW];
      3'd4:    sel = cpt_thr[4*TW +: TW];
      default: sel = '0;
    endcase
  end

  // Stage 0: count neighbours, stage 1: table lookup, stage 2: draw and write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      thr_q <= '0;
      st_q  <= 1'b0;
    end else begin
      if (active && stage == 2'd0) cnt_q <= ones4(nbr);
      if (active && stage == 2'd1) thr_q <= sel;
      if (active && stage == 2'd2) st_q <= ({1'b0, rnd[PW-1:0]} < thr_q);
      else if (load)               st_q <= load_val;
      else if (fault_hit)          st_q <= ~st_q;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/gibbs_ctrl.sv
module gibbs_ctrl
  import gibbs_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] target,
  output logic          busy,
  output logic          phase,
  output logic [1:0]    stage,
  output logic          done
);
  ctl_mode_e     mode_q;
  logic [CW-1:0] tgt_q, cnt_q;
  logic          phase_q, done_q, last_sweep;
  logic [1:0]    stage_q;

  assign last_sweep = (tgt_q == '0) || (cnt_q == tgt_q - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= CTL_IDLE;
      tgt_q   <= '0;
      cnt_q   <= '0;
      phase_q <= 1'b0;
      stage_q <= 2'd0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (mode_q)
        CTL_IDLE: if (start) begin
          mode_q  <= CTL_RUN;
          tgt_q   <= target;
          cnt_q   <= '0;
          phase_q <= 1'b0;
          stage_q <= 2'd0;
        end
        default: begin
          if (stage_q == 2'd2) begin
            stage_q <= 2'd0;
            if (!phase_q) begin
              phase_q <= 1'b1;
            end else begin
              phase_q <= 1'b0;
              if (last_sweep) begin
                mode_q <= CTL_IDLE;
                done_q <= 1'b1;
              end else begin
                cnt_q <= cnt_q + CW'(1);
              end
            end
          end else begin
            stage_q <= stage_q + 2'd1;
          end
        end
      endcase
    end
  end

  assign busy  = (mode_q == CTL_RUN);
  assign phase = phase_q;
  assign stage = stage_q;
  assign done  = done_q;
endmodule

// File: rtl/lattice_gibbs_top.sv
module lattice_gibbs_top
  import gibbs_pkg::*;
#(
  parameter int          N    = 9,
  parameter int          PW   = 8,
  parameter int          CW   = 16,
  parameter logic [31:0] SEED = 32'h2545_F491,
  localparam int         NS   = N * N,
  localparam int         TW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] sweep_target,
  input  logic [5*TW-1:0] cpt_thr,
  input  logic          init_load,
  input  logic [NS-1:0] init_state,
  input  logic          fault_en,
  input  logic [TW-1:0] fault_thr,
  output logic [NS-1:0] lattice_state,
  output logic          busy,
  output logic          sweep_done
);
  logic       ctl_busy, ctl_phase, ctl_done, load_ok;
  logic [1:0] ctl_stage;
  logic [NS-1:0] st;

  gibbs_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .target(sweep_target),
    .busy(ctl_busy), .phase(ctl_phase), .stage(ctl_stage), .done(ctl_done)
  );

  assign load_ok = init_load && !ctl_busy;

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      localparam int IDX = r * N + c;
      logic [3:0] nb;
      if (r > 0)     begin : g_up assign nb[0] = st[IDX-N]; end
      else           begin : g_up0 assign nb[0] = 1'b0; end
      if (r < N - 1) begin : g_dn assign nb[1] = st[IDX+N]; end
      else           begin : g_dn0 assign nb[1] = 1'b0; end
      if (c > 0)     begin : g_lf assign nb[2] = st[IDX-1]; end
      else           begin : g_lf0 assign nb[2] = 1'b0; end
      if (c < N - 1) begin : g_rt assign nb[3] = st[IDX+1]; end
      else           begin : g_rt0 assign nb[3] = 1'b0; end

      gibbs_site #(
        .PW(PW), .SEED(site_seed(SEED, IDX)), .COLOUR((r + c) % 2)
      ) u_site (
        .clk(clk), .rst_n(rst_n), .run(ctl_busy), .phase(ctl_phase),
        .stage(ctl_stage), .nbr(nb), .cpt_thr(cpt_thr),
        .fault_en(fault_en), .fault_thr(fault_thr),
        .load(load_ok), .load_val(init_state[IDX]), .state(st[IDX])
      );
    end
  end

  assign lattice_state = st;
  assign busy          = ctl_busy;
  assign sweep_done    = ctl_done;
endmodule

// File: rtl/gibbs_checker.sv
module gibbs_checker #(
  parameter int N  = 9,
  localparam int NS = N * N
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fault_en,
  input logic          init_load,
  input logic [NS-1:0] lattice_state,
  input logic          busy,
  input logic          sweep_done,
  input logic          phase,
  input logic [1:0]    stage
);
  logic [NS-1:0] odd_mask;
  always_comb
    for (int i = 0; i < NS; i++) odd_mask[i] = (((i / N) + (i % N)) % 2) == 1;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |=> !sweep_done); // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |-> (!busy && $past(busy))); // R8
  AST_DONE_AFTER_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |-> ($past(phase) && $past(stage) == 2'd2)); // R6
  AST_STAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stage != 2'd2) |=> (busy && phase == $past(phase) && stage == $past(stage) + 2'd1)); // R6
  AST_MIDPHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(stage) != 2'd2 && !$past(fault_en)) |-> $stable(lattice_state)); // R7
  AST_OTHER_COLOUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(fault_en)) |->
      (((lattice_state ^ $past(lattice_state)) & ($past(phase) ? ~odd_mask : odd_mask)) == '0)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && !$past(fault_en) && !$past(init_load)) |-> $stable(lattice_state)); // R10
endmodule

bind lattice_gibbs_top gibbs_checker #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .fault_en(fault_en), .init_load(init_load),
  .lattice_state(lattice_state), .busy(busy), .sweep_done(sweep_done),
  .phase(ctl_phase), .stage(ctl_stage)
);

// File: tb/test_lattice_gibbs_top.sv
module test_lattice_gibbs_top;
  localparam int N  = 9;
  localparam int PW = 8;
  localparam int CW = 16;
  localparam int NS = N * N;
  localparam int TW = PW + 1;
  localparam logic [TW-1:0] FULLV = TW'(1) << PW;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, init_load = 1'b0, fault_en = 1'b0;
  logic [CW-1:0]   sweep_target = '0;
  logic [5*TW-1:0] cpt_thr = '0;
  logic [NS-1:0]   init_state = '0, lattice_state, mdl;
  logic [TW-1:0]   fault_thr = '0;
  logic            busy, sweep_done;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  lattice_gibbs_top #(.N(N), .PW(PW), .CW(CW)) i_lattice_gibbs_top (
    .clk(clk), .rst_n(rst_n), .start(start), .sweep_target(sweep_target),
    .cpt_thr(cpt_thr), .init_load(init_load), .init_state(init_state),
    .fault_en(fault_en), .fault_thr(fault_thr), .lattice_state(lattice_state),
    .busy(busy), .sweep_done(sweep_done)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int nbv(input logic [NS-1:0] s, input int r, input int c);
    if (r < 0 || r >= N || c < 0 || c >= N) return 0;
    return int'(s[r*N+c]);
  endfunction

  function automatic logic [NS-1:0] phase_upd(input logic [NS-1:0] s, input int col,
                                              input logic [4:0] full);
    logic [NS-1:0] o;
    o = s;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        if ((r + c) % 2 == col)
          o[r*N+c] = full[nbv(s,r-1,c) + nbv(s,r+1,c) + nbv(s,r,c-1) + nbv(s,r,c+1)];
    return o;
  endfunction

  function automatic logic [5*TW-1:0] table_of(input logic [4:0] full);
    logic [5*TW-1:0] t;
    t = '0;
    for (int k = 0; k < 5; k++) t[k*TW +: TW] = full[k] ? FULLV : '0;
    return t;
  endfunction

  task automatic load_lattice(input logic [NS-1:0] v, input string req);
    @(negedge clk); init_load = 1'b1; init_state = v;
    @(negedge clk); init_load = 1'b0;
    check(lattice_state === v, req, 128'(lattice_state), 128'(v));
    mdl = v;
  endtask

  // Runs a sweep series and follows the lattice every cycle
  task automatic run_sweeps(input int s, input int tgt, input logic [4:0] full,
                            input bit exact, input bit disturb, input string req);
    logic [NS-1:0] cur;
    bit traj_ok, time_ok;
    cur = mdl; traj_ok = 1'b1; time_ok = 1'b1;
    if (exact) cpt_thr = table_of(full);
    @(negedge clk); start = 1'b1; sweep_target = CW'(tgt);
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    if (!busy || sweep_done) time_ok = 1'b0;
    if (exact && lattice_state !== cur) traj_ok = 1'b0;
    for (int j = 1; j <= 6 * s; j++) begin
      if (disturb && j == 2) begin
        start = 1'b1; sweep_target = CW'(s + 3); init_load = 1'b1; init_state = ~cur;
      end
      @(negedge clk);
      start = 1'b0; init_load = 1'b0;
      if (j % 3 == 0) cur = phase_upd(cur, ((j / 3) - 1) % 2, full);
      if (exact && lattice_state !== cur) traj_ok = 1'b0;
      if (j < 6 * s) begin
        if (!busy || sweep_done) time_ok = 1'b0;
      end else if (busy || !sweep_done) time_ok = 1'b0;
    end
    @(negedge clk);
    if (busy || sweep_done) time_ok = 1'b0;
    if (exact && lattice_state !== cur) traj_ok = 1'b0;
    if (!exact) cur = lattice_state;
    check(traj_ok, {req, " R4 R7 trajectory"}, 128'(lattice_state), 128'(cur));
    check(time_ok, {req, " R6 R8 done timing"}, 128'({busy, sweep_done}), 128'(2'b00));
    mdl = cur;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [NS-1:0] v, border;
    int pc;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(lattice_state === '0 && !busy && !sweep_done, "R1 reset",
          128'({lattice_state, busy, sweep_done}), 128'(0));

    // R2 seeding
    v = {$urandom(), $urandom(), $urandom()};
    load_lattice(v, "R2 load");

    // R3 certain tables
    run_sweeps(1, 1, 5'b11111, 1'b1, 1'b0, "R3 all-one table");
    check(lattice_state === '1, "R3 all ones", 128'(lattice_state), 128'({NS{1'b1}}));
    run_sweeps(1, 1, 5'b00000, 1'b1, 1'b0, "R3 all-zero table");
    check(lattice_state === '0, "R3 all zeros", 128'(lattice_state), 128'(0));

    // R5 attractive table keeps all ones; count-4-only clears the border
    load_lattice('1, "R2 load ones");
    run_sweeps(2, 2, 5'b11100, 1'b1, 1'b0, "R5 attractive");
    check(lattice_state === '1, "R5 all ones held", 128'(lattice_state), 128'({NS{1'b1}}));
    load_lattice('1, "R2 load ones");
    run_sweeps(1, 1, 5'b10000, 1'b1, 1'b0, "R5 strict");
    border = '0;
    for (int i = 0; i < N; i++) begin
      border[i] = 1'b1; border[(N-1)*N+i] = 1'b1; border[i*N] = 1'b1; border[i*N+N-1] = 1'b1;
    end
    check((lattice_state & border) === '0, "R5 border reads zero",
          128'(lattice_state & border), 128'(0));

    // R8 target zero gives one sweep
    load_lattice(NS'({$urandom(), $urandom(), $urandom()}), "R2 load");
    run_sweeps(1, 0, 5'b01010, 1'b1, 1'b0, "R8 target zero");

    // R9 start, target and load ignored mid-run
    run_sweeps(2, 2, 5'b00110, 1'b1, 1'b1, "R9 disturbed run");

    // R4 R6 constrained random: certain-valued tables, random seeds and lengths
    for (int it = 0; it < 20; it++) begin
      int s;
      logic [4:0] full;
      s = 1 + int'($urandom() % 3);
      full = 5'($urandom());
      if (it % 4 == 0)
        load_lattice(NS'({$urandom(), $urandom(), $urandom()}), "R2 load random");
      run_sweeps(s, s, full, 1'b1, 1'b0, "R4 random");
    end

    // R10 faults while idle
    load_lattice('0, "R2 load zeros");
    @(negedge clk); fault_thr = FULLV; fault_en = 1'b1;
    @(negedge clk);
    check(lattice_state === '1, "R10 full-rate flip", 128'(lattice_state), 128'({NS{1'b1}}));
    @(negedge clk); fault_en = 1'b0;
    check(lattice_state === '0, "R10 second flip", 128'(lattice_state), 128'(0));
    @(negedge clk);
    @(negedge clk); fault_en = 1'b1; fault_thr = '0;
    check(lattice_state === '0, "R10 disabled holds", 128'(lattice_state), 128'(0));
    repeat (3) @(negedge clk);
    fault_en = 1'b0;
    check(lattice_state === '0, "R10 zero rate holds", 128'(lattice_state), 128'(0));

    // R11 half-probability table mixes the lattice
    mdl = lattice_state;
    for (int k = 0; k < 5; k++) cpt_thr[k*TW +: TW] = TW'(1) << (PW - 1);
    run_sweeps(6, 6, 5'b00000, 1'b0, 1'b0, "R11 half table");
    pc = $countones(lattice_state);
    check(pc >= 20 && pc <= 61, "R11 density", 128'(pc), 128'(NS / 2));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule